// File: doc/BRIEF.md
# Instruction Step Gate

This block decides, once per instruction step of a hart, what that step is. A pending interrupt wins outright: the step reports it with its cause and target privilege, and the fetch stream is not consumed. When no interrupt is pending, the block takes one fetch result from a valid/ready stream. The result may be an extension-specific fetch error, a standard fetch error with a faulting address, or an instruction parcel. The block then settles whether the instruction may execute or must trap.

Two gates apply to instructions. The first is the forward-edge landing-pad rule. While a landing pad is expected, any compressed instruction traps, and so does any 32-bit instruction other than the landing-pad instruction. This rule is checked before the compressed-extension enable. The second gate is that enable: with it off, a compressed instruction is illegal. For an instruction that executes, the block also produces the sequential next PC.

Step results leave through a registered valid/ready output. A result stays on the output, unchanged, until `step_ready` is high at a rising edge. While a result is held and not taken, `fetch_ready` is low and no new step starts. A result may be taken and the next step captured on the same edge.

Top module: `step_gate`

## Requirements
- R1: When `irq_pending` is high, `fetch_ready` is low and the next step reports outcome IRQ (`step_kind` = 5'b00001), with `step_cause` = `irq_cause` and `step_priv` = `irq_priv`. The fetch input is not consumed.
- R2: A fetch of kind 0 (extension error) gives outcome EXT_ERR (5'b00010). Kind 3 is reserved and is handled the same way.
- R3: A fetch of kind 1 (standard error) gives outcome FETCH_ERR (5'b00100), with `step_cause` = `fetch_err_cause` and `step_tval` = `fetch_err_addr`.
- R4: A fetch of kind 2 carries an instruction in `fetch_data`. It is compressed when bits [1:0] are not 2'b11. For a compressed instruction, `step_bits` holds `fetch_data[15:0]` zero-extended to 32 bits; for a 32-bit instruction it holds all of `fetch_data`.
- R5: With `lp_expected` high, a compressed instruction gives outcome TRAP (5'b10000) with cause 18 and tval 2. This happens whatever the parcel holds and whether or not `c_enable` is set.
- R6: With `lp_expected` low, a compressed instruction gives outcome EXEC (5'b01000) with `step_npc` = PC+2 when `c_enable` is high. When `c_enable` is low it gives outcome TRAP with cause 2 and tval equal to the zero-extended bits.
- R7: With `lp_expected` high, a 32-bit instruction gives TRAP with cause 18 and tval 2, unless it is the landing-pad instruction. The landing-pad instruction has opcode [6:0] = 7'b0010111 and rd [11:7] = 0; it gives EXEC with PC+4.
- R8: With `lp_expected` low, a 32-bit instruction gives EXEC with `step_npc` = PC+4.
- R9: Every outcome other than EXEC reports `step_npc` equal to `step_pc`. `step_pc` is the `pc` value sampled when the step starts.
- R10: Every presented step has exactly one outcome bit set. While `step_valid` is high and `step_ready` is low, all step outputs hold their values and `fetch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | 1 | An interrupt is pending |
| irq_cause | input | CAUSE_W | Cause of the pending interrupt |
| irq_priv | input | 2 | Target privilege of the interrupt |
| cur_priv | input | 2 | Current privilege, reported on non-interrupt steps |
| lp_expected | input | 1 | A landing pad is expected |
| c_enable | input | 1 | Compressed extension enabled |
| pc | input | XLEN | Current PC |
| fetch_valid | input | 1 | Fetch result offered |
| fetch_ready | output | 1 | Fetch result accepted at this edge |
| fetch_kind | input | 2 | 0 extension error, 1 standard error, 2 instruction, 3 reserved |
| fetch_data | input | 32 | Instruction parcel |
| fetch_err_cause | input | CAUSE_W | Cause of a standard fetch error |
| fetch_err_addr | input | XLEN | Faulting address of a standard fetch error |
| step_valid | output | 1 | Step result available |
| step_ready | input | 1 | Consumer takes the step result |
| step_kind | output | 5 | One-hot outcome: IRQ, EXT_ERR, FETCH_ERR, EXEC, TRAP (bit 0 to 4) |
| step_cause | output | CAUSE_W | Trap, error or interrupt cause |
| step_priv | output | 2 | Privilege reported with the step |
| step_tval | output | XLEN | Trap value |
| step_bits | output | 32 | Zero-extended instruction bits |
| step_pc | output | XLEN | PC of the step |
| step_npc | output | XLEN | Next PC |

## Verification
A step starts at the rising edge where `fetch_ready` (or `irq_pending`) qualifies it, and its result is on the outputs right after that same edge. The bench therefore drives inputs on a falling edge, waits one rising edge, and samples at the following falling edge. `fetch_ready` is a combinational function of the held output and `irq_pending`, so it is checked on the falling edge before the rising edge it gates. The back-pressure test holds `step_ready` low for several cycles and checks that the outputs do not change. It then raises `step_ready` and checks that the next step is captured on the first edge where the held result is taken.

// File: rtl/step_gate_pkg.sv
package step_gate_pkg;
  localparam int ILEN = 32;

  typedef enum logic [1:0] {
    FK_EXT_ERR = 2'd0,
    FK_STD_ERR = 2'd1,
    FK_INSTR   = 2'd2,
    FK_RSVD    = 2'd3
  } fetch_kind_e;

  localparam int KIND_W = 5;
  localparam logic [KIND_W-1:0] OC_IRQ       = 5'b00001;
  localparam logic [KIND_W-1:0] OC_EXT_ERR   = 5'b00010;
  localparam logic [KIND_W-1:0] OC_FETCH_ERR = 5'b00100;
  localparam logic [KIND_W-1:0] OC_EXEC      = 5'b01000;
  localparam logic [KIND_W-1:0] OC_TRAP      = 5'b10000;

  localparam int CAUSE_ILLEGAL = 2;
  localparam int CAUSE_SWCHECK = 18;
  localparam int LP_FAULT_CODE = 2;

  localparam logic [6:0] OPC_LPAD = 7'b0010111;
endpackage

// File: rtl/step_parcel_class.sv
module step_parcel_class
  import step_gate_pkg::*;
(
  input  logic [ILEN-1:0] raw,
  output logic            is_comp,
  output logic            is_lpad,
  output logic [ILEN-1:0] bits_zx
);
  localparam int HALF = ILEN / 2;

  always_comb begin
    is_comp = (raw[1:0] != 2'b11);
    bits_zx = is_comp ? {{HALF{1'b0}}, raw[HALF-1:0]} : raw;
    is_lpad = !is_comp && (raw[6:0] == OPC_LPAD) && (raw[11:7] == 5'd0);
  end
endmodule

// File: rtl/step_decide.sv
module step_decide
  import step_gate_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               irq_pending,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic [1:0]         irq_priv,
  input  logic [1:0]         cur_priv,
  input  logic               lp_expected,
  input  logic               c_enable,
  input  logic [XLEN-1:0]    pc,
  input  logic [1:0]         fetch_kind,
  input  logic [CAUSE_W-1:0] fetch_err_cause,
  input  logic [XLEN-1:0]    fetch_err_addr,
  input  logic               is_comp,
  input  logic               is_lpad,
  input  logic [ILEN-1:0]    bits_zx,
  output logic [KIND_W-1:0]  kind,
  output logic [CAUSE_W-1:0] cause,
  output logic [1:0]         priv,
  output logic [XLEN-1:0]    tval,
  output logic [ILEN-1:0]    bits,
  output logic [XLEN-1:0]    npc
);
  localparam logic [XLEN-1:0] STEP_C = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(4);

  always_comb begin
    kind  = OC_EXT_ERR;
    cause = '0;
    priv  = cur_priv;
    tval  = '0;
    bits  = '0;
    npc   = pc;
    if (irq_pending) begin
      kind  = OC_IRQ;
      cause = irq_cause;
      priv  = irq_priv;
    end else begin
      case (fetch_kind_e'(fetch_kind))
        FK_STD_ERR: begin
          kind  = OC_FETCH_ERR;
          cause = fetch_err_cause;
          tval  = fetch_err_addr;
        end
        FK_INSTR: begin
          bits = bits_zx;
          if (lp_expected && (is_comp || !is_lpad)) begin
            kind  = OC_TRAP;
            cause = CAUSE_W'(CAUSE_SWCHECK);
            tval  = XLEN'(LP_FAULT_CODE);
          end else if (is_comp && !c_enable) begin
            kind  = OC_TRAP;
            cause = CAUSE_W'(CAUSE_ILLEGAL);
            tval  = XLEN'(bits_zx);
          end else begin
            kind = OC_EXEC;
            npc  = pc + (is_comp ? STEP_C : STEP_W);
          end
        end
        default: kind = OC_EXT_ERR;
      endcase
    end
  end
endmodule

// File: rtl/step_out_stage.sv
module step_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic         free,
  output logic [W-1:0] q
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/step_gate.sv
module step_gate
  import step_gate_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_pending,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  logic [1:0]         irq_priv,
  input  logic [1:0]         cur_priv,
  input  logic               lp_expected,
  input  logic               c_enable,
  input  logic [XLEN-1:0]    pc,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [1:0]         fetch_kind,
  input  logic [31:0]        fetch_data,
  input  logic [CAUSE_W-1:0] fetch_err_cause,
  input  logic [XLEN-1:0]    fetch_err_addr,
  output logic               step_valid,
  input  logic               step_ready,
  output logic [4:0]         step_kind,
  output logic [CAUSE_W-1:0] step_cause,
  output logic [1:0]         step_priv,
  output logic [XLEN-1:0]    step_tval,
  output logic [31:0]        step_bits,
  output logic [XLEN-1:0]    step_pc,
  output logic [XLEN-1:0]    step_npc
);
  localparam int PW = KIND_W + CAUSE_W + 2 + XLEN + ILEN + XLEN + XLEN;

  logic              is_comp, is_lpad;
  logic [ILEN-1:0]   bits_zx;
  logic [KIND_W-1:0] d_kind;
  logic [CAUSE_W-1:0] d_cause;
  logic [1:0]        d_priv;
  logic [XLEN-1:0]   d_tval, d_npc;
  logic [ILEN-1:0]   d_bits;
  logic              out_free, load;
  logic [PW-1:0]     d_pay, q_pay;

  step_parcel_class u_class (
    .raw     (fetch_data),
    .is_comp (is_comp),
    .is_lpad (is_lpad),
    .bits_zx (bits_zx)
  );

  step_decide #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_decide (
    .irq_pending     (irq_pending),
    .irq_cause       (irq_cause),
    .irq_priv        (irq_priv),
    .cur_priv        (cur_priv),
    .lp_expected     (lp_expected),
    .c_enable        (c_enable),
    .pc              (pc),
    .fetch_kind      (fetch_kind),
    .fetch_err_cause (fetch_err_cause),
    .fetch_err_addr  (fetch_err_addr),
    .is_comp         (is_comp),
    .is_lpad         (is_lpad),
    .bits_zx         (bits_zx),
    .kind            (d_kind),
    .cause           (d_cause),
    .priv            (d_priv),
    .tval            (d_tval),
    .bits            (d_bits),
    .npc             (d_npc)
  );

  assign fetch_ready = out_free && !irq_pending;
  assign load        = out_free && (irq_pending || fetch_valid);
  assign d_pay       = {d_kind, d_cause, d_priv, d_tval, d_bits, pc, d_npc};

  step_out_stage #(.W(PW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (d_pay),
    .ready (step_ready),
    .valid (step_valid),
    .free  (out_free),
    .q     (q_pay)
  );

  assign {step_kind, step_cause, step_priv, step_tval, step_bits, step_pc, step_npc} = q_pay;
endmodule

// File: rtl/step_gate_chk.sv
module step_gate_chk
  import step_gate_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_pending,
  input logic               fetch_ready,
  input logic               step_valid,
  input logic               step_ready,
  input logic [4:0]         step_kind,
  input logic [CAUSE_W-1:0] step_cause,
  input logic [XLEN-1:0]    step_tval,
  input logic [31:0]        step_bits,
  input logic [XLEN-1:0]    step_pc,
  input logic [XLEN-1:0]    step_npc
);
  AST_IRQ_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !fetch_ready); // R1
  AST_LP_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_kind == OC_TRAP && step_cause == CAUSE_W'(CAUSE_SWCHECK)
    |-> step_tval == XLEN'(LP_FAULT_CODE)); // R5
  AST_COMP_ZEROEXT: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && (step_kind == OC_EXEC || step_kind == OC_TRAP) && step_bits[1:0] != 2'b11
    |-> step_bits[31:16] == 16'd0); // R4
  AST_COMP_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_kind == OC_EXEC && step_bits[1:0] != 2'b11
    |-> step_npc == step_pc + XLEN'(2)); // R6
  AST_WORD_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_kind == OC_EXEC && step_bits[1:0] == 2'b11
    |-> step_npc == step_pc + XLEN'(4)); // R8
  AST_NONEXEC_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_kind != OC_EXEC |-> step_npc == step_pc); // R9
  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> $countones(step_kind) == 1); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_kind) && $stable(step_npc)
    && $stable(step_bits) && $stable(step_tval)); // R10
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |-> !fetch_ready); // R10
endmodule

bind step_gate step_gate_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_pending (irq_pending),
  .fetch_ready (fetch_ready),
  .step_valid  (step_valid),
  .step_ready  (step_ready),
  .step_kind   (step_kind),
  .step_cause  (step_cause),
  .step_tval   (step_tval),
  .step_bits   (step_bits),
  .step_pc     (step_pc),
  .step_npc    (step_npc)
);

// File: tb/sim_step_gate.sv
`timescale 1ns/1ps
module sim_step_gate;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pending = 1'b0;
  logic [CW-1:0] irq_cause = '0;
  logic [1:0] irq_priv = '0, cur_priv = 2'd0;
  logic lp_expected = 1'b0, c_enable = 1'b1;
  logic [XLEN-1:0] pc = '0;
  logic fetch_valid = 1'b0;
  logic fetch_ready;
  logic [1:0] fetch_kind = '0;
  logic [31:0] fetch_data = '0;
  logic [CW-1:0] fetch_err_cause = '0;
  logic [XLEN-1:0] fetch_err_addr = '0;
  logic step_valid, step_ready = 1'b1;
  logic [4:0] step_kind;
  logic [CW-1:0] step_cause;
  logic [1:0] step_priv;
  logic [XLEN-1:0] step_tval, step_pc, step_npc;
  logic [31:0] step_bits;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  step_gate #(.XLEN(XLEN), .CAUSE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_cause(irq_cause),
    .irq_priv(irq_priv), .cur_priv(cur_priv), .lp_expected(lp_expected),
    .c_enable(c_enable), .pc(pc), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_kind(fetch_kind), .fetch_data(fetch_data), .fetch_err_cause(fetch_err_cause),
    .fetch_err_addr(fetch_err_addr), .step_valid(step_valid), .step_ready(step_ready),
    .step_kind(step_kind), .step_cause(step_cause), .step_priv(step_priv),
    .step_tval(step_tval), .step_bits(step_bits), .step_pc(step_pc), .step_npc(step_npc)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge, capture on the rising edge, sample on the next falling edge.
  task automatic run_step(input logic [1:0] k, input logic [31:0] data, input logic [31:0] p);
    @(negedge clk);
    fetch_kind = k; fetch_data = data; pc = p; fetch_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic expect_step(input string req, input logic [4:0] k, input logic [CW-1:0] c,
                             input logic [31:0] tv, input logic [31:0] b, input logic [31:0] np);
    chk(req, "valid", 64'(step_valid), 64'd1);
    chk(req, "kind", 64'(step_kind), 64'(k));
    chk(req, "cause", 64'(step_cause), 64'(c));
    chk(req, "tval", 64'(step_tval), 64'(tv));
    chk(req, "bits", 64'(step_bits), 64'(b));
    chk(req, "npc", 64'(step_npc), 64'(np));
  endtask

  task automatic t_reset();
    chk("R10", "reset valid", 64'(step_valid), 64'd0);
    chk("R10", "reset fetch_ready", 64'(fetch_ready), 64'd1);
  endtask

  task automatic t_irq();  // R1
    @(negedge clk);
    irq_pending = 1'b1; irq_cause = 6'd7; irq_priv = 2'd3; fetch_valid = 1'b1;
    fetch_kind = 2'd2; fetch_data = 32'h00500093; pc = 32'h100;
    #1 chk("R1", "fetch_ready during irq", 64'(fetch_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    irq_pending = 1'b0; fetch_valid = 1'b0;
    chk("R1", "kind", 64'(step_kind), 64'h01);
    chk("R1", "cause", 64'(step_cause), 64'd7);
    chk("R1", "priv", 64'(step_priv), 64'd3);
    chk("R9", "irq npc", 64'(step_npc), 64'h100);
  endtask

  task automatic t_ext();
    run_step(2'd0, 32'h0, 32'h200);
    chk("R2", "ext kind", 64'(step_kind), 64'h02);
    run_step(2'd3, 32'h0, 32'h204);
    chk("R2", "reserved kind", 64'(step_kind), 64'h02);
    chk("R9", "ext npc", 64'(step_npc), 64'h204);
  endtask

  task automatic t_std();
    fetch_err_cause = 6'd12; fetch_err_addr = 32'hDEAD_0000;
    run_step(2'd1, 32'h0, 32'h300);
    expect_step("R3", 5'b00100, 6'd12, 32'hDEAD_0000, 32'h0, 32'h300);
  endtask

  task automatic t_comp_lp();
    lp_expected = 1'b1; c_enable = 1'b0;
    run_step(2'd2, 32'hABCD_4501, 32'h400);
    expect_step("R5", 5'b10000, 6'd18, 32'd2, 32'h0000_4501, 32'h400);
    c_enable = 1'b1;
    run_step(2'd2, 32'h0000_0001, 32'h402);
    expect_step("R5", 5'b10000, 6'd18, 32'd2, 32'h0000_0001, 32'h402);
    lp_expected = 1'b0;
  endtask

  task automatic t_comp_nolp();
    c_enable = 1'b1;
    run_step(2'd2, 32'hFFFF_4501, 32'h500);
    expect_step("R6", 5'b01000, 6'd0, 32'd0, 32'h0000_4501, 32'h502);
    chk("R4", "zero-extended bits", 64'(step_bits), 64'h4501);
    c_enable = 1'b0;
    run_step(2'd2, 32'h1234_8082, 32'h600);
    expect_step("R6", 5'b10000, 6'd2, 32'h0000_8082, 32'h0000_8082, 32'h600);
    c_enable = 1'b1;
  endtask

  task automatic t_word_lp();
    lp_expected = 1'b1;
    run_step(2'd2, 32'h0050_0093, 32'h700);
    expect_step("R7", 5'b10000, 6'd18, 32'd2, 32'h0050_0093, 32'h700);
    run_step(2'd2, 32'h1234_5017, 32'h704);
    expect_step("R7", 5'b01000, 6'd0, 32'd0, 32'h1234_5017, 32'h708);
    run_step(2'd2, 32'h1234_5097, 32'h708);
    expect_step("R7", 5'b10000, 6'd18, 32'd2, 32'h1234_5097, 32'h708);
    lp_expected = 1'b0;
  endtask

  task automatic t_word();
    c_enable = 1'b0;
    run_step(2'd2, 32'h0050_0093, 32'hFFFF_FFFC);
    expect_step("R8", 5'b01000, 6'd0, 32'd0, 32'h0050_0093, 32'h0000_0000);
    c_enable = 1'b1;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    step_ready = 1'b0;
    run_step(2'd2, 32'h0050_0093, 32'h800);
    fetch_kind = 2'd2; fetch_data = 32'h0000_4501; pc = 32'h804; fetch_valid = 1'b1;
    #1 chk("R10", "fetch_ready while held", 64'(fetch_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R10", "held npc", 64'(step_npc), 64'h804);
    chk("R10", "held bits", 64'(step_bits), 64'h0050_0093);
    chk("R10", "held valid", 64'(step_valid), 64'd1);
    step_ready = 1'b1;
    #1 chk("R10", "fetch_ready on release", 64'(fetch_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    fetch_valid = 1'b0;
    chk("R10", "next step pc", 64'(step_pc), 64'h804);
    chk("R10", "next step npc", 64'(step_npc), 64'h806);
    @(posedge clk); @(negedge clk);
    chk("R10", "drained", 64'(step_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_ext();
    t_std();
    t_comp_lp();
    t_comp_nolp();
    t_word_lp();
    t_word();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule